// File: doc/BRIEF.md
# Back-to-Back Doorbell Forwarder

This block is the outgoing doorbell of a bridge that joins two independent systems. Doorbell bits become pending in two ways. The local processor writes ones to a 16-bit register, and a hardware pulse reports that the write cache has been flushed. The block gathers whatever bits are pending into one posted memory write. That write goes to the doorbell register of the peer bridge, which sits on the far side of the back-to-back link.

Only the bits carried in a write that has been accepted on the outgoing channel are cleared. Bits that arrive while a write is waiting stay pending and go out in the next write. The destination address is the translation base, which points at the peer's first BAR, plus a fixed doorbell offset.

The register accepts writes only through the primary-side address window, and reads always return zero. The whole mechanism is active only while back-to-back mode is enabled.

Top module: `ntb_peer_doorbell`

## Requirements
- R1: Only a write whose byte address equals the register offset 0x140 can set bits. A write to any other address has no effect.
- R2: A write through the primary window (`reg_primary`=1) in back-to-back mode sets every bit among 13:0 that is written as one. Bits written as zero keep their pending value.
- R3: A write through the secondary window (`reg_primary`=0) has no effect.
- R4: `reg_rdata` is zero at all times, whatever bits are pending.
- R5: A one-cycle `flush_done` pulse in back-to-back mode sets bit 14. Software writes to bits 14 and 15 have no effect, and bit 15 is never set.
- R6: When no request is outstanding, mode is enabled and some bit is pending, `req_valid` rises one cycle later. `req_data` then equals the pending pattern as it stood before that edge.
- R7: `req_addr` equals `xlat_base` + `PEER_OFFSET` (default 0x060), with `xlat_base` sampled at the edge where the request is raised.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` hold their values.
- R9: On acceptance (`req_valid` and `req_ready` both high) only the bits in `req_data` are cleared. Bits set at the same edge or during the wait stay pending. `req_valid` is low for the cycle that follows an acceptance.
- R10: While `b2b_mode` is low, no new request is raised, and neither register writes nor `flush_done` set bits. Bits that are already pending are issued once the mode returns.
- R11: Reset (`rst_n` low) clears all pending bits and deasserts `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Byte address of the access |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_primary | input | 1 | 1 when the access came through the primary-side window |
| reg_rdata | output | DATA_W (16) | Read data, always zero |
| flush_done | input | 1 | Write-cache flush finished, one-cycle pulse |
| b2b_mode | input | 1 | Back-to-back mode enable |
| xlat_base | input | XLAT_W (64) | Translation base of the peer's first BAR |
| req_valid | output | 1 | Outgoing posted write request valid |
| req_ready | input | 1 | Outgoing channel accepts the request |
| req_addr | output | XLAT_W (64) | Destination address of the write |
| req_data | output | DATA_W (16) | Doorbell pattern carried by the write |

## Verification
Directed patterns come first. A single primary write isolates issue timing and address formation. A second write made while the channel stalls shows that the held request does not change and that the new bit lands in a later write. A write at the same edge as an acceptance shows that the clear covers only the carried bits. Secondary-window writes, writes to a wrong offset and writes to the top two bits each have to produce no request at all, which separates window, address and mask decoding. A mode-off interval, including one that begins right after a bit is set, tells gating of setting apart from gating of issue. A long random phase then mixes all inputs against the cycle model.

// File: rtl/ntb_db_pkg.sv
package ntb_db_pkg;
   // How the peer doorbell address is formed from the translation base.
   typedef enum logic {
      XLAT_ADD = 1'b0,   // full adder: base + offset
      XLAT_OR  = 1'b1    // base is aligned so the offset can be OR-ed in
   } xlat_mode_e;
endpackage

// File: rtl/ntb_db_decode.sv
module ntb_db_decode #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned SW_BITS    = 14,
   parameter int unsigned FLUSH_BIT  = 14,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h140
) (
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_primary,
   input  logic              flush_done,
   input  logic              b2b_mode,
   output logic [DATA_W-1:0] set_vec
);
   localparam logic [DATA_W-1:0] SW_MASK =
      {{(DATA_W-SW_BITS){1'b0}}, {SW_BITS{1'b1}}};

   logic addr_hit;
   logic sw_write;

   assign addr_hit = (reg_addr == REG_OFFSET);
   assign sw_write = reg_wr & addr_hit & reg_primary;

   always_comb begin
      set_vec = '0;
      if (sw_write) begin
         set_vec = reg_wdata & SW_MASK;
      end
      if (flush_done) begin
         set_vec[FLUSH_BIT] = 1'b1;
      end
      if (!b2b_mode) begin
         set_vec = '0;
      end
   end
endmodule

// File: rtl/ntb_db_pending.sv
module ntb_db_pending #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned RSVD_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] pend
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == RSVD_BIT) begin : g_rsvd
         assign pend[i] = 1'b0;
      end else begin : g_cell
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= 1'b0;
            end else begin
               // a set at the same edge wins over the clear
               q <= (q & ~clr_vec[i]) | set_vec[i];
            end
         end
         assign pend[i] = q;
      end
   end
endmodule

// File: rtl/ntb_db_issuer.sv
module ntb_db_issuer
   import ntb_db_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned XLAT_W = 64,
   parameter logic [XLAT_W-1:0] PEER_OFFSET = 64'h60,
   parameter xlat_mode_e XLAT_MODE = XLAT_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pend,
   input  logic              b2b_mode,
   input  logic [XLAT_W-1:0] xlat_base,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [XLAT_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic [DATA_W-1:0] clr_vec
);
   logic              launch;
   logic              accept;
   logic [XLAT_W-1:0] dest;

   if (XLAT_MODE == XLAT_ADD) begin : g_add
      assign dest = xlat_base + PEER_OFFSET;
   end else begin : g_or
      assign dest = xlat_base | PEER_OFFSET;
   end

   assign launch  = !req_valid && (pend != '0) && b2b_mode;
   assign accept  = req_valid && req_ready;
   assign clr_vec = accept ? req_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_data  <= '0;
      end else if (launch) begin
         req_valid <= 1'b1;
         req_addr  <= dest;
         req_data  <= pend;
      end else if (accept) begin
         req_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ntb_peer_doorbell.sv
module ntb_peer_doorbell
   import ntb_db_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned XLAT_W    = 64,
   parameter int unsigned SW_BITS   = 14,
   parameter logic [ADDR_W-1:0] REG_OFFSET  = 12'h140,
   parameter logic [XLAT_W-1:0] PEER_OFFSET = 64'h60,
   parameter xlat_mode_e XLAT_MODE = XLAT_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_primary,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              flush_done,
   input  logic              b2b_mode,
   input  logic [XLAT_W-1:0] xlat_base,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [XLAT_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data
);
   localparam int unsigned FLUSH_BIT = SW_BITS;
   localparam int unsigned RSVD_BIT  = SW_BITS + 1;

   if (SW_BITS + 2 > DATA_W) begin : g_chk_width
      $error("SW_BITS leaves no room for the flush and reserved bits");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("ADDR_W too small");
   end
   if (XLAT_W < 8) begin : g_chk_xlat
      $error("XLAT_W too small");
   end

   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] pend;

   ntb_db_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_BITS(SW_BITS),
      .FLUSH_BIT(FLUSH_BIT), .REG_OFFSET(REG_OFFSET)
   ) u_decode (
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_primary(reg_primary), .flush_done(flush_done),
      .b2b_mode(b2b_mode), .set_vec(set_vec)
   );

   ntb_db_pending #(
      .DATA_W(DATA_W), .RSVD_BIT(RSVD_BIT)
   ) u_pending (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_vec(clr_vec), .pend(pend)
   );

   ntb_db_issuer #(
      .DATA_W(DATA_W), .XLAT_W(XLAT_W),
      .PEER_OFFSET(PEER_OFFSET), .XLAT_MODE(XLAT_MODE)
   ) u_issuer (
      .clk(clk), .rst_n(rst_n), .pend(pend), .b2b_mode(b2b_mode),
      .xlat_base(xlat_base), .req_ready(req_ready),
      .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .clr_vec(clr_vec)
   );

   // The register is write-only from software's point of view.
   assign reg_rdata = '0;
endmodule

// File: rtl/ntb_db_checker.sv
module ntb_db_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned XLAT_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              b2b_mode,
   input logic              req_valid,
   input logic              req_ready,
   input logic [XLAT_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data
);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_data)));

   assert_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_data != '0));

   assert_rsvd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !req_data[DATA_W-1]);

   assert_no_issue_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !b2b_mode) |=> !req_valid);

   assert_gap_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid);
endmodule

bind ntb_peer_doorbell ntb_db_checker #(
   .DATA_W(DATA_W), .XLAT_W(XLAT_W)
) u_checker (
   .clk(clk), .rst_n(rst_n), .b2b_mode(b2b_mode),
   .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .req_data(req_data)
);

// File: tb/tb_ntb_peer_doorbell.sv
module tb_ntb_peer_doorbell;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 20000;
   localparam logic [63:0] PEER_OFF = 64'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_primary = 1'b0;
   logic [15:0] reg_rdata;
   logic        flush_done = 1'b0;
   logic        b2b_mode = 1'b0;
   logic [63:0] xlat_base = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic [15:0] req_data;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ntb_peer_doorbell dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_primary(reg_primary), .reg_rdata(reg_rdata),
      .flush_done(flush_done), .b2b_mode(b2b_mode), .xlat_base(xlat_base),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data)
   );

   // Behavioural reference model, advanced on every rising edge.
   logic [15:0] m_pend  = '0;
   logic        m_valid = 1'b0;
   logic [15:0] m_data  = '0;
   logic [63:0] m_addr  = '0;

   always @(posedge clk) begin
      logic [15:0] set_bits;
      logic [15:0] nxt;
      if (!rst_n) begin
         m_pend = '0; m_valid = 1'b0; m_data = '0; m_addr = '0;
      end else begin
         set_bits = '0;
         if (b2b_mode) begin
            if (reg_wr && reg_addr == 12'h140 && reg_primary)
               set_bits = reg_wdata & 16'h3FFF;
            if (flush_done) set_bits = set_bits | 16'h4000;
         end
         nxt = m_pend;
         if (m_valid && req_ready) begin
            nxt = nxt & ~m_data;
            m_valid = 1'b0;
         end else if (!m_valid && m_pend != 0 && b2b_mode) begin
            m_valid = 1'b1;
            m_data  = m_pend;
            m_addr  = xlat_base + PEER_OFF;
         end
         m_pend = nxt | set_bits;
      end
   end

   task automatic chk(input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Cycle comparison against the model, away from the rising edge.
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6/R10 req_valid vs model", {63'd0, req_valid}, {63'd0, m_valid});
         chk("R4 read data zero", {48'd0, reg_rdata}, 64'd0);
         if (m_valid) begin
            chk("R6/R9 req_data vs model", {48'd0, req_data}, {48'd0, m_data});
            chk("R7 req_addr vs model", req_addr, m_addr);
         end
      end
   end

   task automatic wr_reg(input logic [11:0] a, input logic [15:0] d,
                         input logic prim);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_primary = prim;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic accept_one();
      @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic run_main();
      logic [63:0] base0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 valid low after reset", {63'd0, req_valid}, 64'd0);
      b2b_mode = 1'b1;
      base0 = 64'h0000_0010_2000_0000;
      xlat_base = base0;

      // R2 R6 R7: single primary write
      wr_reg(12'h140, 16'h0005, 1'b1);
      chk("R6 not yet valid one cycle after set", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      chk("R6 valid", {63'd0, req_valid}, 64'd1);
      chk("R2 R6 data", {48'd0, req_data}, 64'h5);
      chk("R7 address", req_addr, base0 + PEER_OFF);

      // R8: stall with a new write and a changed base
      xlat_base = 64'h0000_00AB_CD00_0000;
      wr_reg(12'h140, 16'h0002, 1'b1);
      repeat (2) @(negedge clk);
      chk("R8 valid held", {63'd0, req_valid}, 64'd1);
      chk("R8 data held", {48'd0, req_data}, 64'h5);
      chk("R8 addr held", req_addr, base0 + PEER_OFF);

      // R9: acceptance clears only the carried bits
      accept_one();
      chk("R9 gap after accept", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      chk("R9 next write valid", {63'd0, req_valid}, 64'd1);
      chk("R9 remaining bit", {48'd0, req_data}, 64'h2);
      chk("R7 new base", req_addr, 64'h0000_00AB_CD00_0000 + PEER_OFF);
      accept_one();
      repeat (2) @(negedge clk);
      chk("R9 idle after drain", {63'd0, req_valid}, 64'd0);

      // R3: secondary window
      wr_reg(12'h140, 16'h00FF, 1'b0);
      repeat (3) @(negedge clk);
      chk("R3 secondary ignored", {63'd0, req_valid}, 64'd0);

      // R1: wrong offset
      wr_reg(12'h144, 16'h00FF, 1'b1);
      repeat (3) @(negedge clk);
      chk("R1 other offset ignored", {63'd0, req_valid}, 64'd0);

      // R5: top bits not writable, flush sets bit 14
      wr_reg(12'h140, 16'hC000, 1'b1);
      repeat (3) @(negedge clk);
      chk("R5 bits 15:14 not writable", {63'd0, req_valid}, 64'd0);
      @(negedge clk); flush_done = 1'b1;
      @(negedge clk); flush_done = 1'b0;
      @(negedge clk);
      chk("R5 flush valid", {63'd0, req_valid}, 64'd1);
      chk("R5 flush bit", {48'd0, req_data}, 64'h4000);
      accept_one();

      // R10: mode off blocks setting
      @(negedge clk); b2b_mode = 1'b0;
      wr_reg(12'h140, 16'h0001, 1'b1);
      @(negedge clk); flush_done = 1'b1;
      @(negedge clk); flush_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 nothing issued while off", {63'd0, req_valid}, 64'd0);
      b2b_mode = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 nothing was set while off", {63'd0, req_valid}, 64'd0);

      // R10: mode off blocks issue of pending bits
      wr_reg(12'h140, 16'h0008, 1'b1);
      b2b_mode = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 pending not issued while off", {63'd0, req_valid}, 64'd0);
      b2b_mode = 1'b1;
      @(negedge clk);
      chk("R10 issued on return", {63'd0, req_valid}, 64'd1);
      chk("R10 data on return", {48'd0, req_data}, 64'h8);

      // R9: set at the acceptance edge survives
      @(negedge clk);
      req_ready = 1'b1;
      reg_wr = 1'b1; reg_addr = 12'h140; reg_wdata = 16'h0008; reg_primary = 1'b1;
      @(negedge clk);
      req_ready = 1'b0; reg_wr = 1'b0;
      chk("R9 gap", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      chk("R9 same bit re-issued", {63'd0, req_valid}, 64'd1);
      chk("R9 same bit data", {48'd0, req_data}, 64'h8);
      accept_one();

      // R11: reset with a request outstanding
      wr_reg(12'h140, 16'h0010, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R11 valid cleared", {63'd0, req_valid}, 64'd0);
      repeat (3) @(negedge clk);
      chk("R11 pending cleared", {63'd0, req_valid}, 64'd0);

      // Random mix, compared against the model every cycle
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         reg_wr      = ($urandom_range(0, 3) == 0);
         reg_addr    = ($urandom_range(0, 4) == 0) ? 12'h144 : 12'h140;
         reg_wdata   = 16'($urandom);
         reg_primary = ($urandom_range(0, 3) != 0);
         flush_done  = ($urandom_range(0, 9) == 0);
         b2b_mode    = ($urandom_range(0, 7) != 0);
         req_ready   = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 15) == 0)
            xlat_base = {32'($urandom), 32'($urandom)};
      end
      @(negedge clk);
      reg_wr = 1'b0; flush_done = 1'b0; req_ready = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      fork
         run_main();
         begin
            repeat (WDOG_CYCLES) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
   end
endmodule